// File: doc/BRIEF.md
# Three-Format Integer Processor Core

This block is a compact multi-cycle processor for a 32-bit load/store instruction set with three fixed formats. The register-register format carries an 11-bit function selector. The register-immediate format carries a 16-bit constant. The jump format carries a 26-bit PC-relative offset. Each instruction takes two clock cycles. The first cycle latches the word presented on the instruction port. The second cycle reads the register file, computes the result and the next PC, performs any data-memory access, and writes back.

The core has 32 registers of 32 bits, and register 0 is hard-wired to zero. Branches compare one register with zero, so there are no condition flags. Comparisons write 0 or 1 into a register. Memory on both ports is byte-addressed and word-wide, and both read paths are combinational. Any fault stops the core for good until reset: an unknown opcode, an unknown function, a stop instruction, or a misaligned data address. When stopped, the core raises `halt` and leaves the PC on the offending instruction.

Top module: `rcore`

## Requirements
- R1: While reset is held and in the first cycle after it, `halt` is 0 and `imem_addr` is 0.
- R2: Register 0 always reads as zero, and a result written to it is discarded.
- R3: Register-register instructions use opcode 0x00, with rs1 in bits 25:21, rs2 in bits 20:16, rd in bits 15:11 and the function in bits 10:0. The functions are: add 0x020, subtract 0x022, and 0x024, or 0x025, xor 0x026.
- R4: The signed comparison functions write 1 to rd when their condition holds and 0 otherwise. They are: equal 0x028, not-equal 0x029, less 0x02A, greater 0x02B, less-or-equal 0x02C, greater-or-equal 0x02D.
- R5: The immediate format places the opcode in bits 31:26, rs1 in bits 25:21, rd in bits 20:16 and the immediate in bits 15:0. Add-immediate (0x08) sign-extends the immediate. Or-immediate (0x0D) zero-extends it.
- R6: Upper-immediate (0x0F) writes the immediate into bits 31:16 of rd and clears bits 15:0.
- R7: Load word (0x23) and store word (0x2B) address memory at rs1 plus the sign-extended immediate. A store writes the register named in bits 20:16.
- R8: Branch-if-zero (0x04) and branch-if-nonzero (0x05) test rs1 against zero. When taken, the next PC is PC+4 plus the sign-extended immediate. When not taken, it is PC+4.
- R9: Jump (0x02) and call (0x03) set the next PC to PC+4 plus the sign-extended 26-bit field in bits 25:0. Call also writes PC+4 into register 31.
- R10: Jump-register (0x12) sets the PC to rs1 and writes no link. Call-register (0x13) writes PC+4 into register 31 and sets the PC to the value rs1 held before that write.
- R11: An undefined opcode or function raises `halt` and freezes the PC at that instruction. That instruction writes nothing.
- R12: A load or store whose address has nonzero bits 1:0 raises `halt` without any memory access. The PC stays on the faulting instruction.
- R13: The stop instruction (0x11) raises `halt` with the PC held at its own address.
- R14: Every instruction takes exactly two cycles, a fetch cycle and then an execute cycle. There is no delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| halt | output | 1 | Core stopped by a fault or a stop instruction |

## Verification
Register contents cannot be seen at the ports. Every stimulus program therefore ends by storing its results to data memory and then executing a stop instruction, and the bench reads those results from its own memory model. The hardest case to reach is a fault that must leave no trace. To check it, the bench fills data memory with a known pattern before each run, places a misaligned or undefined instruction in the middle of a program, and then confirms two things: `imem_addr` stays on that instruction over several cycles, and no later store changed the pattern. The arithmetic functions are swept over all pairs drawn from a set of sign and overflow boundary values.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XW = 32;

  localparam logic [5:0] OP_RR    = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_CALL  = 6'h03;
  localparam logic [5:0] OP_BZ    = 6'h04;
  localparam logic [5:0] OP_BNZ   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_UPPER = 6'h0F;
  localparam logic [5:0] OP_STOP  = 6'h11;
  localparam logic [5:0] OP_JREG  = 6'h12;
  localparam logic [5:0] OP_CALLR = 6'h13;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [10:0] F_ADD = 11'h020;
  localparam logic [10:0] F_SUB = 11'h022;
  localparam logic [10:0] F_AND = 11'h024;
  localparam logic [10:0] F_OR  = 11'h025;
  localparam logic [10:0] F_XOR = 11'h026;
  localparam logic [10:0] F_CEQ = 11'h028;
  localparam logic [10:0] F_CNE = 11'h029;
  localparam logic [10:0] F_CLT = 11'h02A;
  localparam logic [10:0] F_CGT = 11'h02B;
  localparam logic [10:0] F_CLE = 11'h02C;
  localparam logic [10:0] F_CGE = 11'h02D;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [3:0] {
    K_ALU, K_ADDI, K_ORI, K_UPPER, K_LOAD, K_STORE, K_BZ, K_BNZ,
    K_JMP, K_CALL, K_JREG, K_CALLR, K_STOP, K_BAD
  } kind_e;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_e;

  function automatic logic [XW-1:0] sx16(input logic [15:0] v);
    return {{(XW-16){v[15]}}, v};
  endfunction

  function automatic logic [XW-1:0] sx26(input logic [25:0] v);
    return {{(XW-26){v[25]}}, v};
  endfunction

  function automatic logic fn_known(input logic [10:0] f);
    case (f)
      F_ADD, F_SUB, F_AND, F_OR, F_XOR,
      F_CEQ, F_CNE, F_CLT, F_CGT, F_CLE, F_CGE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [XW-1:0] alu_calc(input logic [10:0] f,
                                             input logic [XW-1:0] a,
                                             input logic [XW-1:0] b);
    logic signed [XW-1:0] sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (f)
      F_ADD:   return a + b;
      F_SUB:   return a - b;
      F_AND:   return a & b;
      F_OR:    return a | b;
      F_XOR:   return a ^ b;
      F_CEQ:   return {{(XW-1){1'b0}}, a == b};
      F_CNE:   return {{(XW-1){1'b0}}, a != b};
      F_CLT:   return {{(XW-1){1'b0}}, sa < sb};
      F_CGT:   return {{(XW-1){1'b0}}, sa > sb};
      F_CLE:   return {{(XW-1){1'b0}}, sa <= sb};
      F_CGE:   return {{(XW-1){1'b0}}, sa >= sb};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [31:0] ir,
  output kind_e       kind,
  output logic [4:0]  waddr,
  output logic        wb
);
  always_comb begin
    kind  = K_BAD;
    waddr = ir[20:16];
    wb    = 1'b0;
    case (ir[31:26])
      OP_RR: begin
        kind  = fn_known(ir[10:0]) ? K_ALU : K_BAD;
        waddr = ir[15:11];
        wb    = 1'b1;
      end
      OP_ADDI:  begin kind = K_ADDI;  wb = 1'b1; end
      OP_ORI:   begin kind = K_ORI;   wb = 1'b1; end
      OP_UPPER: begin kind = K_UPPER; wb = 1'b1; end
      OP_LOAD:  begin kind = K_LOAD;  wb = 1'b1; end
      OP_STORE: kind = K_STORE;
      OP_BZ:    kind = K_BZ;
      OP_BNZ:   kind = K_BNZ;
      OP_JMP:   kind = K_JMP;
      OP_JREG:  kind = K_JREG;
      OP_STOP:  kind = K_STOP;
      OP_CALL:  begin kind = K_CALL;  waddr = LINK_REG; wb = 1'b1; end
      OP_CALLR: begin kind = K_CALLR; waddr = LINK_REG; wb = 1'b1; end
      default:  kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && wa == AW'(i)) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[ra];
  assign rdata_b = regs[rb];
endmodule

// File: rtl/rcore_exec.sv
module rcore_exec
  import rcore_pkg::*;
(
  input  kind_e        kind,
  input  logic [31:0]  ir,
  input  logic [31:0]  pc,
  input  logic [31:0]  a,
  input  logic [31:0]  b,
  input  logic [31:0]  ld_data,
  output logic [31:0]  wb_data,
  output logic [31:0]  ea,
  output logic [31:0]  npc,
  output logic         misalign
);
  logic [31:0] pc4;
  logic [15:0] imm;

  assign imm      = ir[15:0];
  assign pc4      = pc + 32'd4;
  assign ea       = a + sx16(imm);
  assign misalign = (kind == K_LOAD || kind == K_STORE) && (ea[1:0] != 2'b00);

  always_comb begin
    npc     = pc4;
    wb_data = '0;
    case (kind)
      K_ALU:   wb_data = alu_calc(ir[10:0], a, b);
      K_ADDI:  wb_data = a + sx16(imm);
      K_ORI:   wb_data = a | {16'h0000, imm};
      K_UPPER: wb_data = {imm, 16'h0000};
      K_LOAD:  wb_data = ld_data;
      K_BZ:    if (a == '0) npc = pc4 + sx16(imm);
      K_BNZ:   if (a != '0) npc = pc4 + sx16(imm);
      K_JMP:   npc = pc4 + sx26(ir[25:0]);
      K_CALL:  begin npc = pc4 + sx26(ir[25:0]); wb_data = pc4; end
      K_JREG:  npc = a;
      K_CALLR: begin npc = a; wb_data = pc4; end
      default: ;
    endcase
  end
endmodule

// File: rtl/rcore.sv
module rcore
  import rcore_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  output logic        dmem_re,
  input  logic [31:0] dmem_rdata,
  output logic        halt
);
  state_e      state;
  logic [31:0] pc, ir;
  kind_e       kind;
  logic [4:0]  dec_waddr;
  logic        dec_wb;
  logic [31:0] rf_rdata_a, rf_rdata_b, wb_data, ea, npc;
  logic        misalign;

  // named events for the checker
  logic        in_fetch, ex_fire, ex_fault, rf_we;
  logic [4:0]  rf_ra, rf_waddr;

  assign in_fetch = (state == S_FETCH);
  assign ex_fire  = (state == S_EXEC);
  assign ex_fault = ex_fire && (kind == K_BAD || kind == K_STOP || misalign);
  assign rf_ra    = ir[25:21];
  assign rf_waddr = dec_waddr;
  assign rf_we    = ex_fire && dec_wb && !ex_fault;

  rcore_decode u_dec (
    .ir(ir), .kind(kind), .waddr(dec_waddr), .wb(dec_wb)
  );

  rcore_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .ra(rf_ra), .rb(ir[20:16]),
    .rdata_a(rf_rdata_a), .rdata_b(rf_rdata_b),
    .we(rf_we), .wa(rf_waddr), .wdata(wb_data)
  );

  rcore_exec u_ex (
    .kind(kind), .ir(ir), .pc(pc), .a(rf_rdata_a), .b(rf_rdata_b),
    .ld_data(dmem_rdata), .wb_data(wb_data), .ea(ea), .npc(npc),
    .misalign(misalign)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      ir    <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= imem_rdata;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (ex_fault) begin
            state <= S_HALT;
          end else begin
            pc    <= npc;
            state <= S_FETCH;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign halt       = (state == S_HALT);
  assign dmem_addr  = ea;
  assign dmem_wdata = rf_rdata_b;
  assign dmem_we    = ex_fire && kind == K_STORE && !misalign;
  assign dmem_re    = ex_fire && kind == K_LOAD && !misalign;
endmodule

// File: rtl/rcore_chk.sv
module rcore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halt,
  input logic [31:0] pc,
  input logic        in_fetch,
  input logic        ex_fire,
  input logic        ex_fault,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic [31:0] dmem_addr,
  input logic [4:0]  rf_ra,
  input logic [31:0] rf_rdata_a
);
  AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_ra == 5'd0) |-> (rf_rdata_a == 32'd0)); // R2
  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && $stable(pc))); // R11
  AST_HALT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!dmem_we && !dmem_re)); // R11
  AST_FAULT_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ex_fault |=> (halt && $stable(pc))); // R12
  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_we || dmem_re) |-> (dmem_addr[1:0] == 2'b00)); // R12
  AST_FETCH_THEN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |=> ex_fire); // R14
  AST_EXEC_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fire && !ex_fault) |=> in_fetch); // R14
endmodule

bind rcore rcore_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .pc(pc), .in_fetch(in_fetch),
  .ex_fire(ex_fire), .ex_fault(ex_fault), .dmem_we(dmem_we),
  .dmem_re(dmem_re), .dmem_addr(dmem_addr), .rf_ra(rf_ra),
  .rf_rdata_a(rf_rdata_a)
);

// File: tb/rcore_test.sv
module rcore_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re, halt;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcore uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .halt(halt)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // encoders with the opcode and function values stated in the requirements
  function automatic logic [31:0] rr(input logic [10:0] f, input int rd, input int s1, input int s2);
    return {6'h00, 5'(s1), 5'(s2), 5'(rd), f};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input int rd, input int s1, input logic [15:0] imm);
    return {op, 5'(s1), 5'(rd), imm};
  endfunction
  function automatic logic [31:0] jj(input logic [5:0] op, input logic [25:0] off);
    return {op, off};
  endfunction
  localparam logic [31:0] STOP = {6'h11, 26'h0};

  function automatic logic [31:0] ref_alu(input logic [10:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      11'h020: return a + b;
      11'h022: return a + ~b + 32'd1;
      11'h024: return a & b;
      11'h025: return a | b;
      11'h026: return a ^ b;
      11'h028: return (a == b) ? 32'd1 : 32'd0;
      11'h029: return (a == b) ? 32'd0 : 32'd1;
      11'h02A: return (sa < sb) ? 32'd1 : 32'd0;
      11'h02B: return (sb < sa) ? 32'd1 : 32'd0;
      11'h02C: return (sb < sa) ? 32'd0 : 32'd1;
      11'h02D: return (sa < sb) ? 32'd0 : 32'd1;
      default: return 32'hx;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = STOP;
      dmem[i] = 32'hDEAD_0000 + 32'(i);
    end
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halt && cyc < 2000) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic load_const(input int base, input int rd, input logic [31:0] v);
    imem[base]   = ii(6'h0F, rd, 0, v[31:16]);
    imem[base+1] = ii(6'h0D, rd, rd, v[15:0]);
  endtask

  localparam logic [31:0] VALS [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                       32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};
  localparam logic [10:0] FUNCS [11] = '{11'h020, 11'h022, 11'h024, 11'h025, 11'h026,
                                         11'h028, 11'h029, 11'h02A, 11'h02B, 11'h02C, 11'h02D};
  localparam logic [15:0] IMMS [5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};

  initial begin
    int cyc;
    logic [31:0] frozen;
    clear_mem();
    // R1: reset state
    rst_n = 1'b0;
    #1;
    check(halt == 1'b0, "R1 halt in reset", {31'b0, halt}, 32'd0);
    check(imem_addr == 32'd0, "R1 pc in reset", imem_addr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(imem_addr == 32'd0 && !halt, "R1 pc after first fetch", imem_addr, 32'd0);

    // R3 R4: function sweep; R14 cycle count
    foreach (FUNCS[fi]) begin
      foreach (VALS[ai]) begin
        foreach (VALS[bi]) begin
          clear_mem();
          load_const(0, 1, VALS[ai]);
          load_const(2, 2, VALS[bi]);
          imem[4] = rr(FUNCS[fi], 3, 1, 2);
          imem[5] = ii(6'h2B, 3, 0, 16'h0);
          imem[6] = STOP;
          run(cyc);
          if (FUNCS[fi] >= 11'h028)
            check(dmem[0] === ref_alu(FUNCS[fi], VALS[ai], VALS[bi]), "R4 compare result",
                  dmem[0], ref_alu(FUNCS[fi], VALS[ai], VALS[bi]));
          else
            check(dmem[0] === ref_alu(FUNCS[fi], VALS[ai], VALS[bi]), "R3 arithmetic result",
                  dmem[0], ref_alu(FUNCS[fi], VALS[ai], VALS[bi]));
          if (fi == 0 && ai == 0 && bi == 0)
            check(cyc == 14, "R14 two cycles per instruction", 32'(cyc), 32'd14);
        end
      end
    end

    // R5: immediate extension
    foreach (VALS[ai]) begin
      foreach (IMMS[k]) begin
        clear_mem();
        load_const(0, 1, VALS[ai]);
        imem[2] = ii(6'h08, 2, 1, IMMS[k]);
        imem[3] = ii(6'h0D, 3, 1, IMMS[k]);
        imem[4] = ii(6'h2B, 2, 0, 16'h0);
        imem[5] = ii(6'h2B, 3, 0, 16'h4);
        run(cyc);
        check(dmem[0] === VALS[ai] + {{16{IMMS[k][15]}}, IMMS[k]}, "R5 add-immediate",
              dmem[0], VALS[ai] + {{16{IMMS[k][15]}}, IMMS[k]});
        check(dmem[1] === (VALS[ai] | {16'h0, IMMS[k]}), "R5 or-immediate",
              dmem[1], VALS[ai] | {16'h0, IMMS[k]});
      end
    end

    // R6: upper immediate clears low half
    clear_mem();
    imem[0] = ii(6'h08, 5, 0, 16'hFFFF);
    imem[1] = ii(6'h0F, 5, 0, 16'hABCD);
    imem[2] = ii(6'h2B, 5, 0, 16'h8);
    run(cyc);
    check(dmem[2] === 32'hABCD_0000, "R6 upper immediate", dmem[2], 32'hABCD_0000);

    // R2: write to register 0 discarded
    clear_mem();
    imem[0] = ii(6'h08, 0, 0, 16'h0007);
    imem[1] = rr(11'h020, 0, 0, 0);
    imem[2] = ii(6'h2B, 0, 0, 16'h0);
    imem[3] = ii(6'h08, 1, 0, 16'h0);
    imem[4] = ii(6'h2B, 1, 0, 16'h4);
    run(cyc);
    check(dmem[0] === 32'h0, "R2 register 0 stays zero", dmem[0], 32'h0);
    check(dmem[1] === 32'h0, "R2 register 0 as source", dmem[1], 32'h0);

    // R7: base plus negative displacement, and absolute with register 0
    clear_mem();
    imem[0] = ii(6'h08, 1, 0, 16'h0040);
    imem[1] = ii(6'h08, 2, 0, 16'h1234);
    imem[2] = ii(6'h2B, 2, 1, 16'hFFF8);
    imem[3] = ii(6'h23, 3, 1, 16'hFFF8);
    imem[4] = ii(6'h08, 3, 3, 16'h0001);
    imem[5] = ii(6'h2B, 3, 0, 16'h0);
    imem[6] = ii(6'h23, 4, 0, 16'h0014);
    imem[7] = ii(6'h2B, 4, 0, 16'h4);
    run(cyc);
    check(dmem[14] === 32'h1234, "R7 store address", dmem[14], 32'h1234);
    check(dmem[0] === 32'h1235, "R7 load data", dmem[0], 32'h1235);
    check(dmem[1] === 32'hDEAD_0005, "R7 absolute load", dmem[1], 32'hDEAD_0005);

    // R8: forward branches, both senses, both outcomes
    for (int op = 4; op <= 5; op++) begin
      for (int v = 0; v <= 1; v++) begin
        bit taken;
        logic [31:0] expv;
        clear_mem();
        imem[0] = ii(6'h08, 1, 0, v ? 16'h5 : 16'h0);
        imem[1] = ii(6'h08, 2, 0, 16'h1);
        imem[2] = ii(6'(op), 0, 1, 16'h0004);
        imem[3] = ii(6'h08, 2, 0, 16'h2);
        imem[4] = ii(6'h2B, 2, 0, 16'h0);
        run(cyc);
        taken = (op == 4) ? (v == 0) : (v != 0);
        expv = taken ? 32'd1 : 32'd2;
        check(dmem[0] === expv, "R8 branch outcome", dmem[0], expv);
      end
    end
    // R8: backward branch loop
    clear_mem();
    imem[0] = ii(6'h08, 1, 0, 16'h3);
    imem[1] = ii(6'h08, 2, 0, 16'h0);
    imem[2] = ii(6'h08, 2, 2, 16'h5);
    imem[3] = ii(6'h08, 1, 1, 16'hFFFF);
    imem[4] = ii(6'h05, 0, 1, 16'hFFF4);
    imem[5] = ii(6'h2B, 2, 0, 16'h0);
    run(cyc);
    check(dmem[0] === 32'd15, "R8 backward loop", dmem[0], 32'd15);

    // R9: jump and call with link
    clear_mem();
    imem[0] = ii(6'h08, 2, 0, 16'h1);
    imem[1] = jj(6'h02, 26'h4);
    imem[2] = ii(6'h08, 2, 0, 16'h9);
    imem[3] = jj(6'h03, 26'h4);
    imem[4] = ii(6'h08, 2, 0, 16'h9);
    imem[5] = ii(6'h2B, 31, 0, 16'h0);
    imem[6] = ii(6'h2B, 2, 0, 16'h4);
    run(cyc);
    check(dmem[0] === 32'd16, "R9 call link value", dmem[0], 32'd16);
    check(dmem[1] === 32'd1, "R9 skipped instructions", dmem[1], 32'd1);

    // R10: call-register links, jump-register does not
    clear_mem();
    imem[0] = ii(6'h08, 4, 0, 16'd20);
    imem[1] = ii(6'h13, 0, 4, 16'h0);
    imem[5] = ii(6'h2B, 31, 0, 16'h0);
    imem[6] = ii(6'h08, 5, 0, 16'd36);
    imem[7] = ii(6'h12, 0, 5, 16'h0);
    imem[8] = ii(6'h2B, 5, 0, 16'h4);
    imem[9] = ii(6'h2B, 31, 0, 16'h8);
    run(cyc);
    check(dmem[0] === 32'd8, "R10 register call link", dmem[0], 32'd8);
    check(dmem[1] === 32'hDEAD_0001, "R10 register jump target", dmem[1], 32'hDEAD_0001);
    check(dmem[2] === 32'd8, "R10 jump-register writes no link", dmem[2], 32'd8);

    // R10: call-register through register 31 uses old value
    clear_mem();
    imem[0] = ii(6'h08, 31, 0, 16'd12);
    imem[1] = ii(6'h13, 0, 31, 16'h0);
    imem[3] = ii(6'h2B, 31, 0, 16'h0);
    run(cyc);
    check(dmem[0] === 32'd8, "R10 self link", dmem[0], 32'd8);

    // R11: undefined opcode and undefined function
    for (int t = 0; t < 2; t++) begin
      clear_mem();
      imem[0] = ii(6'h08, 1, 0, 16'h5);
      imem[1] = ii(6'h2B, 1, 0, 16'h0);
      imem[2] = t ? rr(11'h3FF, 1, 0, 0) : {6'h3F, 26'h0};
      imem[3] = ii(6'h2B, 1, 0, 16'h4);
      run(cyc);
      check(halt === 1'b1, "R11 halt raised", {31'b0, halt}, 32'd1);
      repeat (4) @(negedge clk);
      check(imem_addr === 32'd8, "R11 pc frozen", imem_addr, 32'd8);
      check(dmem[1] === 32'hDEAD_0001, "R11 no later store", dmem[1], 32'hDEAD_0001);
    end

    // R12: misaligned store and load
    clear_mem();
    imem[0] = ii(6'h08, 1, 0, 16'h7);
    imem[1] = ii(6'h08, 2, 0, 16'h2);
    imem[2] = ii(6'h2B, 1, 2, 16'h0);
    imem[3] = ii(6'h2B, 1, 0, 16'h4);
    run(cyc);
    frozen = imem_addr;
    check(halt === 1'b1 && frozen === 32'd8, "R12 misaligned store halts", frozen, 32'd8);
    check(dmem[0] === 32'hDEAD_0000, "R12 no write at word 0", dmem[0], 32'hDEAD_0000);
    check(dmem[1] === 32'hDEAD_0001, "R12 no later store", dmem[1], 32'hDEAD_0001);
    clear_mem();
    imem[0] = ii(6'h08, 1, 0, 16'h7);
    imem[1] = ii(6'h08, 2, 0, 16'h2);
    imem[2] = ii(6'h23, 3, 0, 16'h1);
    imem[3] = ii(6'h2B, 1, 0, 16'h4);
    run(cyc);
    check(halt === 1'b1 && imem_addr === 32'd8, "R12 misaligned load halts", imem_addr, 32'd8);
    check(dmem[1] === 32'hDEAD_0001, "R12 load fault no store", dmem[1], 32'hDEAD_0001);

    // R13: stop instruction
    clear_mem();
    imem[0] = ii(6'h08, 1, 0, 16'h1);
    imem[1] = ii(6'h08, 1, 0, 16'h2);
    imem[2] = ii(6'h08, 1, 0, 16'h3);
    imem[3] = STOP;
    imem[4] = ii(6'h2B, 1, 0, 16'h0);
    run(cyc);
    check(halt === 1'b1 && imem_addr === 32'd12, "R13 stop address", imem_addr, 32'd12);
    check(cyc == 8, "R13 R14 stop timing", 32'(cyc), 32'd8);
    check(dmem[0] === 32'hDEAD_0000, "R13 nothing after stop", dmem[0], 32'hDEAD_0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule